// File: doc/BRIEF.md
# Join Node Controller for a Request/Acknowledge Dataflow Pipeline

This block controls one processing node in a dataflow pipeline whose stages talk through request/acknowledge handshakes. The node has several input channels and several output channels. It stays idle until a datagram is pending on every input channel, takes all of them in the same cycle, and then spends a compute interval whose length arrives as a cycle count on a delay input. The result is offered on one output channel only and held there until that channel acknowledges, after which the node is free to accept the next set of inputs.

Successive results go to the output channels in turn, starting with channel 0. The compute function is a stand-in (the modular sum of all consumed input words). A two-bit state output and one saturating cycle counter per state let a surrounding system measure how much of the time the node is productive, idle or stalled on its consumer.

Top module: `jn_node`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the state output reads free (0), no input acknowledge and no output request is asserted, and all three cycle counters read zero.
- R2: In the free state, when every bit of `in_req` is high at a clock edge, the node consumes all inputs at once: every bit of `in_ack` is high for exactly the next cycle, and never does only a subset of `in_ack` bits go high.
- R3: In the busy and waiting states the node consumes nothing: `in_req` is ignored and `in_ack` stays low.
- R4: The value on `dly_in` is sampled at the consumption edge; with a sampled value d, the output request becomes visible d+1 cycles after the consumption edge, so a delay of zero gives the result in the next cycle. No output request is high in the busy state.
- R5: At most one `out_req` bit is ever high. `out_data` carries the sum, modulo 2^DW, of the DW-bit words consumed from all inputs, and both request and data stay unchanged while the node waits for the acknowledge.
- R6: Results are assigned to outputs in round-robin order 0, 1, ..., M-1, 0, ...; the pointer advances only when the selected output acknowledges, and the node then returns to free in the next cycle.
- R7: An `out_ack` bit on an output that is not currently requested has no effect on state, pointer, request or data.
- R8: `state_o` encodes free as 0, busy as 1 and waiting as 2; the value 3 never appears.
- R9: Each counter (`cnt_free`, `cnt_busy`, `cnt_wait`) increases by one for every cycle the node spends in its state and stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | N_IN | Per-input request: datagram pending |
| in_data | input | N_IN*DW | Input datagrams, channel i at bits [i*DW +: DW] |
| in_ack | output | N_IN | Per-input acknowledge, pulsed together on consumption |
| dly_in | input | DLY_W | Compute interval in cycles, sampled on consumption |
| out_req | output | M_OUT | Per-output request, at most one high |
| out_ack | input | M_OUT | Per-output acknowledge from consumers |
| out_data | output | DW | Result datagram |
| state_o | output | 2 | Node state: 0 free, 1 busy, 2 waiting |
| cnt_free | output | CNT_W | Saturating count of free cycles |
| cnt_busy | output | CNT_W | Saturating count of busy cycles |
| cnt_wait | output | CNT_W | Saturating count of waiting cycles |

## Verification
The node is driven with inputs that arrive staggered, so the join must hold off until the last one appears, and with inputs that are all present back to back, which tests that no set is consumed twice and that the acknowledges come as one group. The delay input is swept over random values and pinned at zero and at its maximum to separate off-by-one errors in the compute interval, and a slow consumer keeps the node waiting long enough to show that the result stays stable and nothing new is taken in. Stray acknowledges on unselected outputs are mixed in throughout, which tells a correct round-robin pointer apart from one that moves on any acknowledge; narrow counters reach saturation early in the run.

// File: rtl/jn_pkg.sv
package jn_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_BUSY = 2'd1,
    ST_WAIT = 2'd2
  } node_st_e;
  localparam int NUM_ST = 3;
endpackage

// File: rtl/jn_join.sv
// Captures the combined input datagrams and acknowledges all inputs together.
module jn_join #(
  parameter int N_IN = 3,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [N_IN-1:0]    in_ack,
  output logic [DW-1:0]      result
);
  logic [DW-1:0] acc;

  // Placeholder compute function: modular sum of all input words.
  always_comb begin
    acc = '0;
    for (int i = 0; i < N_IN; i++) begin
      acc = acc + in_data[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ack <= '0;
      result <= '0;
    end else begin
      in_ack <= fire ? {N_IN{1'b1}} : '0;
      if (fire) result <= acc;
    end
  end
endmodule

// File: rtl/jn_seq.sv
// Free / busy / waiting sequencer with the compute interval counter.
module jn_seq
  import jn_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_ready,
  input  logic [DLY_W-1:0] dly_in,
  input  logic             delivered,
  output node_st_e         state,
  output logic             fire,
  output logic             done
);
  logic [DLY_W-1:0] remain;

  assign fire = (state == ST_FREE) && all_ready;
  assign done = (state == ST_BUSY) && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FREE;
      remain <= '0;
    end else begin
      unique case (state)
        ST_FREE: begin
          if (fire) begin
            state  <= ST_BUSY;
            remain <= dly_in;
          end
        end
        ST_BUSY: begin
          if (done) state <= ST_WAIT;
          else      remain <= remain - 1'b1;
        end
        ST_WAIT: begin
          if (delivered) state <= ST_FREE;
        end
        default: state <= ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/jn_route.sv
// Presents each result on one output, rotating round-robin on acknowledge.
module jn_route #(
  parameter int M_OUT = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [DW-1:0]    result,
  input  logic [M_OUT-1:0] out_ack,
  output logic [M_OUT-1:0] out_req,
  output logic [DW-1:0]    out_data,
  output logic             delivered
);
  localparam int PTR_W = (M_OUT > 1) ? $clog2(M_OUT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(M_OUT - 1);

  logic [PTR_W-1:0] ptr;
  logic [M_OUT-1:0] sel_hot;

  for (genvar k = 0; k < M_OUT; k++) begin : g_dec
    assign sel_hot[k] = (ptr == PTR_W'(k));
  end

  assign delivered = |(out_req & out_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      out_req  <= '0;
      out_data <= '0;
    end else if (done) begin
      out_req  <= sel_hot;
      out_data <= result;
    end else if (delivered) begin
      out_req <= '0;
      ptr     <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/jn_util.sv
// One saturating cycle counter per node state.
module jn_util
  import jn_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  node_st_e                state,
  output logic [NUM_ST*CNT_W-1:0] cnt_flat
);
  for (genvar s = 0; s < NUM_ST; s++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if ((state == node_st_e'(s)) && (cnt_q != {CNT_W{1'b1}})) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_flat[s*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/jn_node.sv
module jn_node
  import jn_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int M_OUT = 3,
  parameter int DW    = 8,
  parameter int DLY_W = 4,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IN-1:0]    in_req,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [N_IN-1:0]    in_ack,
  input  logic [DLY_W-1:0]   dly_in,
  output logic [M_OUT-1:0]   out_req,
  input  logic [M_OUT-1:0]   out_ack,
  output logic [DW-1:0]      out_data,
  output logic [1:0]         state_o,
  output logic [CNT_W-1:0]   cnt_free,
  output logic [CNT_W-1:0]   cnt_busy,
  output logic [CNT_W-1:0]   cnt_wait
);
  node_st_e                  state;
  logic                      fire;
  logic                      done;
  logic                      delivered;
  logic [DW-1:0]             result;
  logic [NUM_ST*CNT_W-1:0]   cnt_flat;

  jn_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .all_ready(&in_req), .dly_in(dly_in),
    .delivered(delivered), .state(state), .fire(fire), .done(done)
  );

  jn_join #(.N_IN(N_IN), .DW(DW)) u_join (
    .clk(clk), .rst(rst), .fire(fire), .in_data(in_data),
    .in_ack(in_ack), .result(result)
  );

  jn_route #(.M_OUT(M_OUT), .DW(DW)) u_route (
    .clk(clk), .rst(rst), .done(done), .result(result), .out_ack(out_ack),
    .out_req(out_req), .out_data(out_data), .delivered(delivered)
  );

  jn_util #(.CNT_W(CNT_W)) u_util (
    .clk(clk), .rst(rst), .state(state), .cnt_flat(cnt_flat)
  );

  assign state_o  = state;
  assign cnt_free = cnt_flat[0*CNT_W +: CNT_W];
  assign cnt_busy = cnt_flat[1*CNT_W +: CNT_W];
  assign cnt_wait = cnt_flat[2*CNT_W +: CNT_W];
endmodule

// File: rtl/jn_node_chk.sv
module jn_node_chk #(
  parameter int N_IN  = 3,
  parameter int M_OUT = 3,
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IN-1:0]  in_ack,
  input logic [M_OUT-1:0] out_req,
  input logic [M_OUT-1:0] out_ack,
  input logic [DW-1:0]    out_data,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] cnt_free,
  input logic [CNT_W-1:0] cnt_wait
);
  p_ack_group_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ack == '0) || (&in_ack));

  p_ack_after_free_r3: assert property (@(posedge clk) disable iff (rst)
    (|in_ack) |-> ($past(state_o) == 2'd0));

  p_no_req_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |-> (out_req == '0));

  p_single_out_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_req));

  p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
    ((|out_req) && !(|(out_req & out_ack))) |=> ((out_req == $past(out_req)) && $stable(out_data)));

  p_wait_has_req_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> $onehot(out_req));

  p_state_legal_r8: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'd3);

  p_sat_free_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_free == {CNT_W{1'b1}}) |=> (cnt_free == {CNT_W{1'b1}}));

  p_sat_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wait == {CNT_W{1'b1}}) |=> (cnt_wait == {CNT_W{1'b1}}));
endmodule

bind jn_node jn_node_chk #(.N_IN(N_IN), .M_OUT(M_OUT), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_ack(in_ack), .out_req(out_req), .out_ack(out_ack),
  .out_data(out_data), .state_o(state_o), .cnt_free(cnt_free), .cnt_wait(cnt_wait)
);

// File: tb/jn_node_tb_top.sv
module jn_node_tb_top;
  localparam int N  = 3;
  localparam int M  = 3;
  localparam int DW = 8;
  localparam int LW = 4;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_req = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_ack;
  logic [LW-1:0]   dly_in = '0;
  logic [M-1:0]    out_req;
  logic [M-1:0]    out_ack = '0;
  logic [DW-1:0]   out_data;
  logic [1:0]      state_o;
  logic [CW-1:0]   cnt_free, cnt_busy, cnt_wait;

  always #5 clk = ~clk;

  jn_node #(.N_IN(N), .M_OUT(M), .DW(DW), .DLY_W(LW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .dly_in(dly_in), .out_req(out_req), .out_ack(out_ack), .out_data(out_data),
    .state_o(state_o), .cnt_free(cnt_free), .cnt_busy(cnt_busy), .cnt_wait(cnt_wait)
  );

  // Behavioural reference model
  int m_st, m_cnt, m_ptr;
  bit m_oreq, m_ack;
  int m_res, m_odata;
  int m_c[3];

  always @(posedge clk) begin
    int ost;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_ptr = 0; m_oreq = 0; m_ack = 0;
      m_res = 0; m_odata = 0;
      for (int s = 0; s < 3; s++) m_c[s] = 0;
    end else begin
      ost = m_st;
      if (m_c[ost] < CMAX) m_c[ost]++;
      m_ack = 0;
      case (ost)
        0: if (in_req == {N{1'b1}}) begin
             m_ack = 1;
             m_res = 0;
             for (int i = 0; i < N; i++) m_res = (m_res + int'(in_data[i*DW +: DW])) % (1 << DW);
             m_cnt = int'(dly_in);
             m_st = 1;
           end
        1: if (m_cnt == 0) begin
             m_oreq = 1; m_odata = m_res; m_st = 2;
           end else m_cnt--;
        default: if (out_ack[m_ptr]) begin
             m_oreq = 0; m_ptr = (m_ptr + 1) % M; m_st = 0;
           end
      endcase
    end
  end

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  int preq = 50, pack = 50, dmode = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int exp_req;
    if (!finished) begin
      vectors++;
      exp_req = m_oreq ? (1 << m_ptr) : 0;
      // R1 covered in reset cycles by the same comparisons; R8 encoding of state
      chk(rst ? "R1" : "R8", "state", int'(state_o), m_st);
      chk(m_ack ? "R2" : "R3", "in_ack", int'(in_ack), m_ack ? ((1 << N) - 1) : 0);
      chk(m_oreq ? "R6" : "R4", "out_req", int'(out_req), exp_req);
      if (m_oreq) chk("R5", "out_data", int'(out_data), m_odata);
      chk("R9", "cnt_free", int'(cnt_free), m_c[0]);
      chk("R9", "cnt_busy", int'(cnt_busy), m_c[1]);
      chk("R9", "cnt_wait", int'(cnt_wait), m_c[2]);
      if (out_ack != '0 && (out_ack & out_req) == '0 && m_oreq)
        chk("R7", "stray ack ignored, state", int'(state_o), 2);

      // Producers: drop request after the acknowledge, re-raise at random
      for (int i = 0; i < N; i++) begin
        if (in_req[i] && in_ack[i]) begin
          in_req[i] = 1'b0;
          in_data[i*DW +: DW] = DW'($urandom);
        end else if (!in_req[i] && ($urandom_range(99) < preq)) begin
          in_req[i] = 1'b1;
        end
      end
      // Consumers: acknowledge the requested output sometimes, others at random
      for (int k = 0; k < M; k++) begin
        if (out_req[k]) out_ack[k] = ($urandom_range(99) < pack);
        else            out_ack[k] = ($urandom_range(99) < 15);
      end
      case (dmode)
        1:       dly_in = '0;
        2:       dly_in = '1;
        default: dly_in = LW'($urandom);
      endcase
    end
  end

  task automatic run_phase(input int rq, input int ak, input int dm, input int cyc);
    preq = rq; pack = ak; dmode = dm;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run_phase(90, 90, 0, 2500);  // R2 back-to-back inputs
    run_phase(8, 60, 0, 2500);   // R2 staggered arrival, join waits for last input
    run_phase(70, 5, 0, 2500);   // R5 R6 R7 slow consumer, stray acks
    run_phase(80, 80, 1, 2000);  // R4 zero delay
    @(negedge clk) rst = 1'b1;   // R1 mid-run reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_phase(60, 70, 2, 2500);  // R4 maximum delay, R9 saturation
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule